// File: doc/BRIEF.md
# Programmable Multi-Line Edge Detector

This block watches a wide bus of single-bit trace lines (256 by default). Each line can report a rising edge, a falling edge or any transition. Each line has a 2-bit edge selector and a mask bit. Both sit in a bank of 32-bit registers that is reached through a plain write strobe, an address and a combinational read-data port. A control register holds a single enable bit. Software loads the selectors and masks first, then sets the enable bit.

Each line keeps a registered copy of its last sampled value. When the block is enabled, every clock compares that copy with the live input. Lines that match their selected edge and are not masked raise their bit in the event vector. The vector is registered, so it shows the edges seen at the previous clock edge. A single any-event flag is registered alongside it. On the first enabled cycle the previous-value copies only load the inputs, so nothing is reported on that cycle.

Top module: `trace_edge_detect`

## Requirements
- R1: After reset every selector, mask and enable bit is zero, every register reads zero, and the event vector and the any-event flag are zero.
- R2: Selector word n sits at byte offset 0x808 + 4*n (n = 0..15) and reads back what was written. Line i is controlled by bits [2*(i mod 16)+1 : 2*(i mod 16)] of word i/16.
- R3: Mask word n sits at byte offset 0x848 + 4*n (n = 0..7) and reads back what was written. Line i is controlled by bit i mod 32 of word i/32.
- R4: Selector code 00 reports a line whose previous sample is 0 and whose current sample is 1, and nothing else.
- R5: Selector code 01 reports a line whose previous sample is 1 and whose current sample is 0, and nothing else.
- R6: Selector code 10 reports any change between the previous and the current sample.
- R7: Selector code 11 never reports an event on its line.
- R8: A mask bit of 1 suppresses every event on its line. A mask bit of 0 lets events through.
- R9: Bit 0 of the register at offset 0x780 enables detection and reads back; its other bits read zero. While the bit is clear no events are reported. On the first cycle after it is set, the previous-value copies load the inputs and no event is reported.
- R10: Reads of any offset other than those in R2, R3 and R9, including offsets that are not a multiple of 4, return zero. Writes to such offsets change no register.
- R11: The any-event flag equals the OR of the event vector in every cycle.
- R12: An event for an input change sampled at clock edge k appears on the event vector right after edge k and lasts exactly one cycle unless the input changes again. A write changes the behaviour from the edge after the write edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr_i | input | 1 | Register write strobe, one write per cycle |
| reg_addr_i | input | 12 | Byte address for reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| line_i | input | 256 | Trace lines being watched |
| evt_o | output | 256 | Registered per-line event vector |
| any_evt_o | output | 1 | Registered OR of all reported events |

## Verification
An input change applied during a cycle is sampled at the next rising edge, and its event is on the outputs right after that edge. The bench drives inputs at the falling edge and compares the event vector and the any-event flag at the following falling edge, one full clock later. Read data is combinational, so it is checked a settling delay after the address changes, with no clock in between. A write lands at the same rising edge that samples the inputs. The bench's model therefore scores that edge with the configuration from before the write, and lets the enable bit affect priming only from the following edge.

// File: rtl/edge_det_pkg.sv
package edge_det_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_sel_e;

  localparam int SEL_BITS = 2;

endpackage

// File: rtl/edge_cfg_bank.sv
module edge_cfg_bank
  import edge_det_pkg::*;
#(
  parameter int                NUM_LINES = 256,
  parameter int                DATA_W    = 32,
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CTL_OFF   = 12'h780,
  parameter logic [ADDR_W-1:0] SEL_BASE  = 12'h808,
  parameter logic [ADDR_W-1:0] MSK_BASE  = 12'h848
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic                          en_o,
  output logic [SEL_BITS*NUM_LINES-1:0] sel_o,
  output logic [NUM_LINES-1:0]          mask_o
);

  localparam int SEL_WORDS = (SEL_BITS * NUM_LINES) / DATA_W;
  localparam int MSK_WORDS = NUM_LINES / DATA_W;
  localparam int SEL_IDX_W = (SEL_WORDS > 1) ? $clog2(SEL_WORDS) : 1;
  localparam int MSK_IDX_W = (MSK_WORDS > 1) ? $clog2(MSK_WORDS) : 1;
  localparam logic [ADDR_W-1:0] SEL_END = SEL_BASE + ADDR_W'(4 * SEL_WORDS);
  localparam logic [ADDR_W-1:0] MSK_END = MSK_BASE + ADDR_W'(4 * MSK_WORDS);

  logic              aligned;
  logic              ctl_hit;
  logic              sel_range;
  logic              msk_range;
  logic [ADDR_W-1:0] sel_off;
  logic [ADDR_W-1:0] msk_off;
  logic [SEL_IDX_W-1:0] sel_idx;
  logic [MSK_IDX_W-1:0] msk_idx;

  always_comb begin
    aligned   = (addr_i[1:0] == 2'b00);
    ctl_hit   = (addr_i == CTL_OFF);
    sel_range = aligned && (addr_i >= SEL_BASE) && (addr_i < SEL_END);
    msk_range = aligned && (addr_i >= MSK_BASE) && (addr_i < MSK_END);
    sel_off   = addr_i - SEL_BASE;
    msk_off   = addr_i - MSK_BASE;
    sel_idx   = sel_off[SEL_IDX_W+1:2];
    msk_idx   = msk_off[MSK_IDX_W+1:2];
  end

  // control register: only bit 0 is stored
  logic en_q, en_d, en_ce;
  logic [DATA_W-2:0] unused_ctl_bits;

  always_comb begin
    en_ce           = wr_i && ctl_hit;
    en_d            = wdata_i[0];
    unused_ctl_bits = wdata_i[DATA_W-1:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_ce) en_q <= en_d;
  end

  assign en_o = en_q;

  // selector words
  for (genvar w = 0; w < SEL_WORDS; w++) begin : g_sel
    logic [DATA_W-1:0] word_q;
    logic              word_ce;

    always_comb word_ce = wr_i && sel_range && (sel_idx == SEL_IDX_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_ce) word_q <= wdata_i;
    end

    assign sel_o[w*DATA_W +: DATA_W] = word_q;
  end

  // mask words
  for (genvar w = 0; w < MSK_WORDS; w++) begin : g_msk
    logic [DATA_W-1:0] word_q;
    logic              word_ce;

    always_comb word_ce = wr_i && msk_range && (msk_idx == MSK_IDX_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_ce) word_q <= wdata_i;
    end

    assign mask_o[w*DATA_W +: DATA_W] = word_q;
  end

  // read mux, unimplemented offsets return zero
  always_comb begin
    rdata_o = '0;
    if (ctl_hit)        rdata_o = {{(DATA_W-1){1'b0}}, en_q};
    else if (sel_range) rdata_o = sel_o[sel_idx*DATA_W +: DATA_W];
    else if (msk_range) rdata_o = mask_o[msk_idx*DATA_W +: DATA_W];
  end

endmodule

// File: rtl/edge_lane.sv
module edge_lane
  import edge_det_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_en,
  input  logic                cur_i,
  input  logic [SEL_BITS-1:0] sel_i,
  input  logic                mask_i,
  output logic                hit_o
);

  logic prev_q, prev_d;
  logic match;

  always_comb prev_d = load_en ? cur_i : prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  always_comb begin
    unique case (edge_sel_e'(sel_i))
      EDGE_RISE: match = !prev_q &&  cur_i;
      EDGE_FALL: match =  prev_q && !cur_i;
      EDGE_BOTH: match =  prev_q ^   cur_i;
      default:   match = 1'b0;
    endcase
    hit_o = match && !mask_i;
  end

endmodule

// File: rtl/edge_core.sv
module edge_core
  import edge_det_pkg::*;
#(
  parameter int NUM_LINES = 256
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en_i,
  input  logic [NUM_LINES-1:0]          line_i,
  input  logic [SEL_BITS*NUM_LINES-1:0] sel_i,
  input  logic [NUM_LINES-1:0]          mask_i,
  output logic [NUM_LINES-1:0]          evt_o,
  output logic                          any_o
);

  logic [NUM_LINES-1:0] hits;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_lane
    edge_lane u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (en_i),
      .cur_i   (line_i[i]),
      .sel_i   (sel_i[SEL_BITS*i +: SEL_BITS]),
      .mask_i  (mask_i[i]),
      .hit_o   (hits[i])
    );
  end

  // primed: set one cycle after enable, once the previous copies hold real samples
  logic primed_q, primed_d;
  logic [NUM_LINES-1:0] evt_q, evt_d;
  logic any_q, any_d;

  always_comb begin
    primed_d = en_i;
    evt_d    = (en_i && primed_q) ? hits : '0;
    any_d    = |evt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      evt_q    <= '0;
      any_q    <= 1'b0;
    end else begin
      primed_q <= primed_d;
      evt_q    <= evt_d;
      any_q    <= any_d;
    end
  end

  assign evt_o = evt_q;
  assign any_o = any_q;

endmodule

// File: rtl/trace_edge_detect.sv
module trace_edge_detect
  import edge_det_pkg::*;
#(
  parameter int NUM_LINES = 256,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  input  logic [NUM_LINES-1:0] line_i,
  output logic [NUM_LINES-1:0] evt_o,
  output logic                 any_evt_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_core_n = rst_sync_q[1];

  logic                          en_w;
  logic [SEL_BITS*NUM_LINES-1:0] sel_w;
  logic [NUM_LINES-1:0]          mask_w;

  edge_cfg_bank #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .en_o    (en_w),
    .sel_o   (sel_w),
    .mask_o  (mask_w)
  );

  edge_core #(
    .NUM_LINES (NUM_LINES)
  ) u_core (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .en_i   (en_w),
    .line_i (line_i),
    .sel_i  (sel_w),
    .mask_i (mask_w),
    .evt_o  (evt_o),
    .any_o  (any_evt_o)
  );

endmodule

// File: rtl/edge_detect_chk.sv
module edge_detect_chk
  import edge_det_pkg::*;
#(
  parameter int NUM_LINES = 256
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          ctl_en,
  input logic [NUM_LINES-1:0]          line_i,
  input logic [SEL_BITS*NUM_LINES-1:0] sel_v,
  input logic [NUM_LINES-1:0]          mask_v,
  input logic [NUM_LINES-1:0]          evt_o,
  input logic                          any_evt_o
);

  logic [NUM_LINES-1:0] reserved_v;
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_res
    assign reserved_v[i] = sel_v[2*i] && sel_v[2*i+1];
  end

  // R11
  any_matches_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt_o == (|evt_o));

  // R9
  off_means_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> (evt_o == '0));

  // R9
  first_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_en) |=> (evt_o == '0));

  // R8
  masked_line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o & $past(mask_v)) == '0);

  // R7
  reserved_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o & $past(reserved_v)) == '0);

  // R12
  event_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o & ~($past(line_i) ^ $past(line_i, 2))) == '0);

endmodule

bind trace_edge_detect edge_detect_chk #(.NUM_LINES(NUM_LINES)) u_edge_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_en    (en_w),
  .line_i    (line_i),
  .sel_v     (sel_w),
  .mask_v    (mask_w),
  .evt_o     (evt_o),
  .any_evt_o (any_evt_o)
);

// File: tb/tb_trace_edge_detect.sv
`timescale 1ns/1ps
module tb_trace_edge_detect;

  localparam int N      = 256;
  localparam int DW     = 32;
  localparam int AW     = 12;
  localparam int NSEL   = 16;
  localparam int NMSK   = 8;
  localparam realtime TCLK = 20.0;

  logic          clk;
  logic          rst_n;
  logic          reg_wr;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;
  logic [N-1:0]  line_in;
  logic [N-1:0]  evt;
  logic          any_evt;

  trace_edge_detect dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .line_i      (line_in),
    .evt_o       (evt),
    .any_evt_o   (any_evt)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model of the register bank and line history
  logic [DW-1:0] m_sel [NSEL];
  logic [DW-1:0] m_msk [NMSK];
  logic          m_en;
  logic          m_primed;
  logic [N-1:0]  m_prev;
  logic [N-1:0]  exp_evt;

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model_hits(input logic [N-1:0] p, input logic [N-1:0] c);
    logic [N-1:0] h;
    for (int i = 0; i < N; i++) begin
      logic [1:0] s;
      logic m;
      s = m_sel[i/16][(i%16)*2 +: 2];
      m = m_msk[i/32][i%32];
      case (s)
        2'b00:   h[i] = !p[i] && c[i];
        2'b01:   h[i] = p[i] && !c[i];
        2'b10:   h[i] = p[i] ^ c[i];
        default: h[i] = 1'b0;
      endcase
      if (m) h[i] = 1'b0;
    end
    return h;
  endfunction

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
    if (a == 12'h780) return {{(DW-1){1'b0}}, m_en};
    if (a[1:0] != 2'b00) return '0;
    if (a >= 12'h808 && a < 12'h848) return m_sel[(a - 12'h808) >> 2];
    if (a >= 12'h848 && a < 12'h868) return m_msk[(a - 12'h848) >> 2];
    return '0;
  endfunction

  task automatic model_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (a == 12'h780) m_en = d[0];
    else if (a[1:0] == 2'b00 && a >= 12'h808 && a < 12'h848) m_sel[(a - 12'h808) >> 2] = d;
    else if (a[1:0] == 2'b00 && a >= 12'h848 && a < 12'h868) m_msk[(a - 12'h848) >> 2] = d;
  endtask

  // one clock: apply at falling edge, score at the next falling edge
  task automatic cycle(input logic [N-1:0] nin, input logic w,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    line_in   = nin;
    reg_wr    = w;
    reg_addr  = a;
    reg_wdata = d;
    exp_evt   = (m_en && m_primed) ? model_hits(m_prev, nin) : '0;
    m_primed  = m_en;
    if (m_en) m_prev = nin;
    if (w) model_write(a, d);
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R12 event vector", evt, exp_evt);
    chk("R11 any-event flag", N'(any_evt), N'(|exp_evt));
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a);
    reg_addr = a;
    #1;
    chk(tag, N'(reg_rdata), N'(model_read(a)));
  endtask

  initial begin
    #(TCLK * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] cur;
    void'($urandom(32'd4711));
    for (int k = 0; k < NSEL; k++) m_sel[k] = '0;
    for (int k = 0; k < NMSK; k++) m_msk[k] = '0;
    m_en = 0; m_primed = 0; m_prev = '0;
    rst_n = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0; line_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 events after reset", evt, '0);
    chk("R1 any after reset", N'(any_evt), '0);
    rd_chk("R1 control reads zero", 12'h780);
    rd_chk("R1 selector word reads zero", 12'h80C);
    rd_chk("R1 mask word reads zero", 12'h864);

    // R2/R3 directed setup: lines 0..3 use 00,01,10,11; line 4 rises but masked
    cycle('0, 1'b1, 12'h808, 32'h0000_00E4);
    rd_chk("R2 selector word 0 readback", 12'h808);
    cycle('0, 1'b1, 12'h844, 32'hA5A5_0F0F);
    rd_chk("R2 selector word 15 readback", 12'h844);
    cycle('0, 1'b1, 12'h848, 32'h0000_0010);
    rd_chk("R3 mask word 0 readback", 12'h848);
    cycle('0, 1'b1, 12'h864, 32'h1234_5678);
    rd_chk("R3 mask word 7 readback", 12'h864);

    // R10: unimplemented and misaligned offsets
    cycle('0, 1'b1, 12'h804, 32'hFFFF_FFFF);
    rd_chk("R10 hole reads zero", 12'h804);
    cycle('0, 1'b1, 12'h809, 32'hFFFF_FFFF);
    rd_chk("R10 misaligned read zero", 12'h809);
    rd_chk("R10 misaligned write ignored", 12'h808);
    cycle('0, 1'b1, 12'h868, 32'hFFFF_FFFF);
    rd_chk("R10 past mask bank", 12'h868);
    rd_chk("R10 mask word 7 untouched", 12'h864);

    // R9: disabled, toggles give nothing
    cycle({N{1'b1}}, 1'b0, '0, '0);
    chk("R9 disabled quiet", evt, '0);
    cycle('0, 1'b1, 12'h780, 32'hFFFF_FFFF);
    rd_chk("R9 enable reads back as bit0", 12'h780);
    // first enabled cycle: lines 0..4 rise, still quiet
    cycle(N'(32'h1F), 1'b0, '0, '0);
    chk("R9 first enabled cycle quiet", evt, '0);
    // falls
    cycle('0, 1'b0, '0, '0);
    chk("R5 falling code fires", N'(evt[1]), N'(1'b1));
    chk("R6 toggle code fires on fall", N'(evt[2]), N'(1'b1));
    chk("R4 rise code silent on fall", N'(evt[0]), N'(1'b0));
    chk("R7 reserved code silent", N'(evt[3]), N'(1'b0));
    // rises
    cycle(N'(32'h1F), 1'b0, '0, '0);
    chk("R4 rise code fires", N'(evt[0]), N'(1'b1));
    chk("R6 toggle code fires on rise", N'(evt[2]), N'(1'b1));
    chk("R5 fall code silent on rise", N'(evt[1]), N'(1'b0));
    chk("R8 masked line silent", N'(evt[4]), N'(1'b0));
    // steady input: event lasts one cycle only
    cycle(N'(32'h1F), 1'b0, '0, '0);
    chk("R12 single-cycle event", evt, '0);

    // random phase
    cur = N'(32'h1F);
    for (int n = 0; n < 4000; n++) begin
      logic [N-1:0] flip;
      logic w;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      int r;
      for (int k = 0; k < N/32; k++)
        flip[k*32 +: 32] = $urandom() & $urandom() & $urandom();
      cur = cur ^ flip;
      r = $urandom_range(0, 99);
      w = 1'b0; a = '0; d = $urandom();
      if (r < 6) begin
        w = 1'b1; a = 12'h808 + AW'(4 * $urandom_range(0, NSEL-1));
      end else if (r < 10) begin
        w = 1'b1; a = 12'h848 + AW'(4 * $urandom_range(0, NMSK-1));
        d = d & $urandom();
      end else if (r < 12) begin
        w = 1'b1; a = 12'h780; d = {31'h0, ($urandom_range(0, 3) != 0)};
      end else if (r < 13) begin
        w = 1'b1; a = AW'($urandom());
      end
      cycle(cur, w, a, d);
      if ((n % 8) == 0) begin
        if ($urandom_range(0, 1) == 0) rd_chk("R2 R3 R9 R10 random read", AW'($urandom()));
        else rd_chk("R2 R3 random word read", 12'h808 + AW'(4 * $urandom_range(0, NSEL+NMSK-1)));
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule